// File: doc/BRIEF.md
# Interrupt Flag and Vector Unit for a Two-Channel Serial Port

This block gathers the interrupt events of a serial port that has two channels: an asynchronous channel A and a synchronous channel B. Each channel has a receive source and a transmit source, which gives four flags. Hardware events set the flags. Software owns an enable register, and a global enable input gates the whole block. The receive sources of both channels share one request line, and the transmit sources share another. Handler code tells the two channels apart by reading the flag register.

Software reaches the block through a small register port. Address 0 is the flag register, which can be read or written. Address 1 is the enable register, which can be read or written. Address 2 is the vector register, which is read only. A read of the vector returns a code for the highest-priority source that is both pending and enabled, and the same read clears that source's flag. Two other actions also clear flags as a side effect: a read of a channel's receive data register, and a load of a channel's transmit buffer. The serial shifters are outside this block. They deliver the strobes and the buffer-empty levels.

Top module: `irq_flag_vector_unit`

## Requirements
- R1: A pulse on `rx_done[c]` sets the RX flag of channel c at the next clock edge, whatever the enable bits hold. Flag and enable bit positions are: bit 0 channel A RX, bit 1 channel B RX, bit 2 channel A TX, bit 3 channel B TX.
- R2: `rx_irq` is high exactly when `gie` is high and some RX flag has its enable bit set. `tx_irq` follows the same rule for the TX flags. Both lines are combinational from the registered state, so they are valid in the cycle after the event edge.
- R3: While `tx_empty[c]` is high, the TX flag of channel c is set on every clock edge, even when its enable bit is clear. A software clear therefore does not stick while the buffer stays empty. A `tx_load[c]` pulse with `tx_empty[c]` low clears that flag.
- R4: A `rx_rd[c]` pulse (a read of the receive data register) clears the RX flag of channel c, with no register write needed.
- R5: The RX sources of both channels drive the single `rx_irq`, and the TX sources of both channels drive the single `tx_irq`. The flag register read at address 0 shows which sources are set. Address 3 reads as zero.
- R6: A read at address 2 returns 0 when no enabled source is pending. Otherwise it returns 2 for channel A RX, 4 for channel B RX, 6 for channel A TX or 8 for channel B TX, taking the first pending enabled source in that order. The code does not depend on `gie`.
- R7: A vector read clears only the flag it reported, at the clock edge that ends the read.
- R8: A write at address 0 loads all flag bits from `reg_wdata[3:0]`, which sets or clears them directly. A write at address 1 loads the enable bits.
- R9: When a hardware set and any clear (data-register read, buffer load, vector read or software write of 0) reach the same flag in the same cycle, the flag ends up set.
- R10: A flag that is set while its enable bit is clear never raises a request line and never shows in the vector code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears flags and enables |
| gie | input | 1 | Global interrupt enable |
| rx_done | input | NUM_CH | Per-channel byte-received strobe |
| rx_rd | input | NUM_CH | Per-channel receive data register read strobe |
| tx_empty | input | NUM_CH | Per-channel transmit buffer empty level |
| tx_load | input | NUM_CH | Per-channel transmit buffer write strobe |
| reg_addr | input | 2 | Register select: 0 flags, 1 enables, 2 vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the vector) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational register read data |
| rx_irq | output | 1 | Shared receive interrupt request |
| tx_irq | output | 1 | Shared transmit interrupt request |

## Verification
Every flag update, whether from a hardware set or from any of the clears, lands at the clock edge that ends the stimulus cycle. The request lines and the read data follow that edge combinationally. Read data is also valid during the read cycle itself, before the vector read's clear takes effect. The bench therefore drives on falling edges and samples request lines and flags at the next falling edge. It checks vector codes during the read cycle and the cleared flag one falling edge later, so each result is observed in the single cycle where it is first due.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      RA_FLAGS  = 2'd0,
      RA_ENABLE = 2'd1,
      RA_VECTOR = 2'd2,
      RA_NONE   = 2'd3
   } reg_addr_e;

   // Code reported for source index idx (lowest index is highest priority)
   function automatic int unsigned src_code(int unsigned idx, int unsigned step);
      return step * (idx + 1);
   endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   input  logic            wr_i,
   input  logic [NSRC-1:0] wdata_i,
   output logic [NSRC-1:0] flags_o
);
   logic [NSRC-1:0] flags_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      logic nxt;
      always_comb begin
         nxt = wr_i ? wdata_i[i] : flags_q[i];
         if (clr_i[i]) nxt = 1'b0;
         if (set_i[i]) nxt = 1'b1;   // hardware set has the last word
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q[i] <= 1'b0;
         else        flags_q[i] <= nxt;
      end

      // R1 / R3 / R9: any hardware set is visible after the edge
      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flags_q[i]);
      // R4 / R7: a clear without a competing set takes effect
      a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !flags_q[i]);
      // R8: a plain software write loads the bit
      a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_i && !set_i[i] && !clr_i[i]) |=> (flags_q[i] == $past(wdata_i[i])));
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/irq_vector_enc.sv
module irq_vector_enc #(
   parameter int unsigned NSRC     = 4,
   parameter int unsigned VEC_STEP = 2,
   parameter int unsigned VEC_W    = 4
) (
   input  logic [NSRC-1:0]  pend_i,
   output logic [NSRC-1:0]  sel_o,
   output logic [VEC_W-1:0] code_o
);
   import irq_pkg::*;

   for (genvar i = 0; i < NSRC; i++) begin : g_pri
      if (i == 0) begin : g_top
         assign sel_o[i] = pend_i[i];
      end else begin : g_low
         assign sel_o[i] = pend_i[i] & ~(|pend_i[i-1:0]);
      end
   end

   always_comb begin
      code_o = '0;
      for (int unsigned i = 0; i < NSRC; i++) begin
         if (sel_o[i]) code_o = VEC_W'(src_code(i, VEC_STEP));
      end
   end
endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
   parameter int unsigned NUM_CH      = 2,
   parameter bit          REQ_OUT_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                gie_i,
   input  logic [2*NUM_CH-1:0] armed_i,   // flags & enables
   output logic                rx_irq_o,
   output logic                tx_irq_o
);
   logic rx_any, tx_any;
   assign rx_any = gie_i & (|armed_i[NUM_CH-1:0]);
   assign tx_any = gie_i & (|armed_i[2*NUM_CH-1:NUM_CH]);

   if (REQ_OUT_REG) begin : g_reg
      logic rx_q, tx_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rx_q <= 1'b0;
            tx_q <= 1'b0;
         end else begin
            rx_q <= rx_any;
            tx_q <= tx_any;
         end
      end
      assign rx_irq_o = rx_q;
      assign tx_irq_o = tx_q;
   end else begin : g_comb
      assign rx_irq_o = rx_any;
      assign tx_irq_o = tx_any;
      // R2: global enable low silences both shared lines
      a_r2_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
         !gie_i |-> (!rx_irq_o && !tx_irq_o));
   end
endmodule

// File: rtl/irq_flag_vector_unit.sv
module irq_flag_vector_unit #(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned VEC_STEP    = 2,
   parameter bit          REQ_OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gie,
   input  logic [NUM_CH-1:0] rx_done,
   input  logic [NUM_CH-1:0] rx_rd,
   input  logic [NUM_CH-1:0] tx_empty,
   input  logic [NUM_CH-1:0] tx_load,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              rx_irq,
   output logic              tx_irq
);
   import irq_pkg::*;

   localparam int unsigned NSRC  = 2 * NUM_CH;
   localparam int unsigned VEC_W = $clog2(VEC_STEP * NSRC + 1);

   if (NUM_CH < 1)       begin : g_chk_ch   $error("NUM_CH must be at least 1");      end
   if (DATA_W < NSRC)    begin : g_chk_dw   $error("DATA_W too narrow for flags");    end
   if (DATA_W < VEC_W)   begin : g_chk_vw   $error("DATA_W too narrow for vector");   end
   if (VEC_STEP < 1)     begin : g_chk_step $error("VEC_STEP must be nonzero");       end

   logic [NSRC-1:0]  flags, en_q, pend, vsel, hw_set, clr;
   logic [VEC_W-1:0] vcode;
   logic             wr_flags, wr_en, rd_vec;

   assign wr_flags = reg_wr && (reg_addr == RA_FLAGS);
   assign wr_en    = reg_wr && (reg_addr == RA_ENABLE);
   assign rd_vec   = reg_rd && (reg_addr == RA_VECTOR);

   // source order: RX of each channel, then TX of each channel
   assign hw_set = {tx_empty, rx_done};
   assign clr    = {tx_load, rx_rd} | (rd_vec ? vsel : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= reg_wdata[NSRC-1:0];
   end

   irq_flag_bank #(.NSRC(NSRC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (hw_set),
      .clr_i   (clr),
      .wr_i    (wr_flags),
      .wdata_i (reg_wdata[NSRC-1:0]),
      .flags_o (flags)
   );

   assign pend = flags & en_q;

   irq_vector_enc #(.NSRC(NSRC), .VEC_STEP(VEC_STEP), .VEC_W(VEC_W)) u_vec (
      .pend_i (pend),
      .sel_o  (vsel),
      .code_o (vcode)
   );

   irq_req_merge #(.NUM_CH(NUM_CH), .REQ_OUT_REG(REQ_OUT_REG)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .gie_i    (gie),
      .armed_i  (pend),
      .rx_irq_o (rx_irq),
      .tx_irq_o (tx_irq)
   );

   always_comb begin
      unique case (reg_addr_e'(reg_addr))
         RA_FLAGS:  reg_rdata = DATA_W'(flags);
         RA_ENABLE: reg_rdata = DATA_W'(en_q);
         RA_VECTOR: reg_rdata = DATA_W'(vcode);
         default:   reg_rdata = '0;
      endcase
   end

   // R6: at most one source is selected for the vector
   a_r6_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vsel));
   // R10: a nonzero code always belongs to an enabled source
   a_r10_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      (vcode != '0) |-> (|(vsel & en_q)));
   // R7: the reported source is cleared by the read unless re-set by hardware
   a_r7_vec_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vec && (vsel != '0) && ((vsel & hw_set) == '0)) |=> ((flags & $past(vsel)) == '0));
endmodule

// File: tb/irq_flag_vector_unit_tb_top.sv
module irq_flag_vector_unit_tb_top;
   localparam int NUM_CH = 2;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              gie = 1'b0;
   logic [NUM_CH-1:0] rx_done = '0, rx_rd = '0, tx_empty = '0, tx_load = '0;
   logic [1:0]        reg_addr = '0;
   logic              reg_wr = 1'b0, reg_rd = 1'b0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              rx_irq, tx_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_flag_vector_unit #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .gie(gie),
      .rx_done(rx_done), .rx_rd(rx_rd), .tx_empty(tx_empty), .tx_load(tx_load),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   // {flags[14:11], enables[10:7], gie[6], rx_irq[5], tx_irq[4], vector[3:0]}
   localparam logic [14:0] TBL [0:7] = '{
      {4'b0001, 4'b0001, 1'b1, 1'b1, 1'b0, 4'd2},
      {4'b0010, 4'b0011, 1'b1, 1'b1, 1'b0, 4'd4},
      {4'b1100, 4'b1111, 1'b1, 1'b0, 1'b1, 4'd6},
      {4'b1000, 4'b1000, 1'b1, 1'b0, 1'b1, 4'd8},
      {4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0, 4'd2},
      {4'b0101, 4'b0000, 1'b1, 1'b0, 1'b0, 4'd0},
      {4'b1111, 4'b1010, 1'b1, 1'b1, 1'b1, 4'd4},
      {4'b0011, 4'b1100, 1'b1, 1'b0, 1'b0, 4'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   function automatic int rd_now(input logic [1:0] a);
      return int'(reg_rdata);
   endfunction

   task automatic peek(input logic [1:0] a, output int v);
      reg_addr = a; #1; v = int'(reg_rdata);
   endtask

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      peek(2'd0, v); chk("R8 reset flags", v, 0);
      peek(2'd1, v); chk("R8 reset enables", v, 0);
      peek(2'd2, v); chk("R6 reset vector", v, 0);
      chk("R2 reset rx_irq", rx_irq, 0);
      chk("R2 reset tx_irq", tx_irq, 0);

      // table walk: R2 R5 R6 R7 R10
      for (int k = 0; k < 8; k++) begin
         logic [14:0] e;
         int expf;
         e = TBL[k];
         bus_wr(2'd0, {4'b0, e[14:11]});
         bus_wr(2'd1, {4'b0, e[10:7]});
         gie = e[6];
         #1;
         chk("R2/R5/R10 rx_irq", rx_irq, e[5]);
         chk("R2/R5/R10 tx_irq", tx_irq, e[4]);
         reg_addr = 2'd2; reg_rd = 1'b1; #1;
         chk("R6/R10 vector", int'(reg_rdata), int'(e[3:0]));
         @(negedge clk);
         reg_rd = 1'b0;
         expf = (e[3:0] == 0) ? int'(e[14:11]) : int'(e[14:11]) & ~(1 << (e[3:0]/2 - 1));
         peek(2'd0, v); chk("R7 flags after vector read", v, expf);
      end
      peek(2'd3, v); chk("R5 unused address", v, 0);

      // R1 + R10: event sets flag with enables clear, no request
      bus_wr(2'd0, 8'h00);
      bus_wr(2'd1, 8'h00);
      gie = 1'b1;
      rx_done = 2'b01;
      @(negedge clk); rx_done = '0;
      peek(2'd0, v); chk("R1 flag set while disabled", v, 1);
      chk("R10 no rx_irq when disabled", rx_irq, 0);
      peek(2'd2, v); chk("R10 vector hides disabled", v, 0);

      // R4: receive data read clears
      rx_rd = 2'b01;
      @(negedge clk); rx_rd = '0;
      peek(2'd0, v); chk("R4 rx read clears", v, 0);

      // R2 latency: enabled event raises line the cycle after the edge
      bus_wr(2'd1, 8'h02);
      rx_done = 2'b10;
      #1; chk("R2 no early rx_irq", rx_irq, 0);
      @(negedge clk); rx_done = '0;
      chk("R2 rx_irq after event", rx_irq, 1);
      peek(2'd2, v); chk("R6 channel B RX code", v, 4);

      // R9: set and receive-read clear in same cycle
      rx_done = 2'b10; rx_rd = 2'b10;
      @(negedge clk); rx_done = '0; rx_rd = '0;
      peek(2'd0, v); chk("R9 set beats rx read", v, 2);
      bus_wr(2'd0, 8'h00);

      // R3: TX flag follows empty buffer, survives software clear
      bus_wr(2'd1, 8'h00);
      tx_empty = 2'b10;
      @(negedge clk);
      peek(2'd0, v); chk("R3 tx flag while disabled", v, 8);
      chk("R10 no tx_irq when disabled", tx_irq, 0);
      bus_wr(2'd0, 8'h00);
      peek(2'd0, v); chk("R9 set beats software clear", v, 8);
      bus_wr(2'd1, 8'h08);
      reg_addr = 2'd2; reg_rd = 1'b1; #1;
      chk("R6 channel B TX code", int'(reg_rdata), 8);
      @(negedge clk); reg_rd = 1'b0;
      peek(2'd0, v); chk("R9 set beats vector read", v, 8);
      chk("R2 tx_irq while empty", tx_irq, 1);
      tx_empty = '0; tx_load = 2'b10;
      @(negedge clk); tx_load = '0;
      peek(2'd0, v); chk("R3 buffer load clears tx flag", v, 0);
      chk("R2 tx_irq drops", tx_irq, 0);

      done = 1'b1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule